// File: doc/BRIEF.md
# Arithmetic Logic Unit with Status Flags

This block computes one of eight arithmetic or bitwise operations on two operands of a configurable width (8, 16 or 32 bits). The result comes out combinationally in the same cycle as its inputs. Six status flags are derived from that result: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. They are captured in a flag register on a rising clock edge, but only while the flag-write enable is high.

A surrounding datapath sets the opcode, operands and carry-in. It reads the result at once. It raises the flag-write enable for those instructions whose outcome must be remembered for later conditional decisions. The add-with-carry and subtract-with-borrow opcodes take the carry-in, so wide arithmetic can be chained across several cycles.

Top module: `alu_flags_unit`

## Requirements
- R1: Operand and result width is set by parameter W (8, 16 or 32; default 32). The most significant bit is W-1.
- R2: res_o follows the inputs combinationally. The op_i encoding is: 0 a+b, 1 a+b+cin, 2 a-b, 3 a-b-cin, 4 a AND b, 5 a OR b, 6 a XOR b, 7 NOT a. All results are truncated to W bits.
- R3: The carry flag is the carry out of bit W-1 for opcodes 0 and 1. For opcodes 2 and 3 it is the borrow, set when a is unsigned-less-than the amount subtracted.
- R4: The zero flag is set when the W-bit result is zero. The sign flag equals result bit W-1.
- R5: The parity flag is set when the low 8 bits of the result contain an even number of ones.
- R6: For opcodes 0 to 3, the auxiliary flag is the carry (add) or the borrow (subtract) from bit 3 into bit 4.
- R7: For add opcodes, overflow is set when a and b have the same sign and the result's sign differs from it. For subtract opcodes, it is set when a and b differ in sign and the result's sign differs from a's.
- R8: Opcodes 4 to 7 write carry, overflow and auxiliary flags as 0.
- R9: flags_o is {overflow, sign, zero, auxiliary, parity, carry} from bit 5 down to bit 0. It loads the flags of the current inputs on a rising edge with flag_we_i high. Otherwise it keeps its value.
- R10: A synchronous active-high rst clears flags_o to 0, and it takes priority over flag_we_i.
- R11: cin_i has no effect on the result or flags of opcodes 0, 2 and 4 to 7. Opcode 7 also ignores b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation select |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry/borrow in for opcodes 1 and 3 |
| flag_we_i | input | 1 | Flag register write enable |
| res_o | output | W | Combinational result |
| flags_o | output | 6 | Registered status flags |

## Verification
The flag assertions compare the registered flags with res_o as it stood one cycle earlier. They therefore assume that the operands and opcode stay steady from the sampling edge until the result has settled. The bench changes inputs only on falling edges and checks flags after the following rising edge, so this assumption holds. Random stimulus draws every opcode, enable and carry-in value. Directed cases cover the sign and carry boundaries at 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and the nibble edge at 0xF.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_NOT = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } alu_flags_t;

    localparam int FLAG_BITS = $bits(alu_flags_t);

    function automatic logic op_is_logic(input alu_op_e op);
        return op[2];
    endfunction

    function automatic logic op_is_sub(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB);
    endfunction

    function automatic logic op_uses_cin(input alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

    function automatic logic bit_logic(input alu_op_e op, input logic x, input logic y);
        case (op)
            OP_AND:  return x & y;
            OP_OR:   return x | y;
            OP_XOR:  return x ^ y;
            default: return ~x;
        endcase
    endfunction

    function automatic logic even_ones(input logic [7:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cf,
    output logic           af,
    output logic           of
);
    localparam int MSB = W - 1;

    logic           sub;
    logic           ci;
    logic [W-1:0]   bx;
    logic [W:0]     full;
    logic [4:0]     low_nib;

    always_comb begin
        sub     = op_is_sub(op);
        ci      = sub ^ (op_uses_cin(op) & cin);
        bx      = sub ? ~b : b;
        full    = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
        low_nib = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'b0000, ci};
        sum     = full[W-1:0];
        cf      = full[W] ^ sub;
        af      = low_nib[4] ^ sub;
        of      = (a[MSB] == bx[MSB]) && (full[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = bit_logic(op, a[i], b[i]);
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic           is_logic,
    input  logic [W-1:0]   res,
    input  logic           ar_cf,
    input  logic           ar_af,
    input  logic           ar_of,
    output alu_flags_t     flags_q
);
    localparam int MSB = W - 1;

    alu_flags_t next_f;

    always_comb begin
        next_f.ovf = is_logic ? 1'b0 : ar_of;
        next_f.sgn = res[MSB];
        next_f.zro = (res == '0);
        next_f.aux = is_logic ? 1'b0 : ar_af;
        next_f.par = even_ones(res[7:0]);
        next_f.cry = is_logic ? 1'b0 : ar_cf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (we) begin
            flags_q <= next_f;
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            op_i,
    input  logic [W-1:0]          a_i,
    input  logic [W-1:0]          b_i,
    input  logic                  cin_i,
    input  logic                  flag_we_i,
    output logic [W-1:0]          res_o,
    output logic [FLAG_BITS-1:0]  flags_o
);
    alu_op_e      op;
    logic [W-1:0] ar_sum;
    logic [W-1:0] lg_res;
    logic         ar_cf;
    logic         ar_af;
    logic         ar_of;
    logic         is_log;
    alu_flags_t   flags_q;

    assign op     = alu_op_e'(op_i);
    assign is_log = op_is_logic(op);

    alu_addsub #(.W(W)) u_addsub (
        .op (op),
        .a  (a_i),
        .b  (b_i),
        .cin(cin_i),
        .sum(ar_sum),
        .cf (ar_cf),
        .af (ar_af),
        .of (ar_of)
    );

    alu_logic #(.W(W)) u_logic (
        .op(op),
        .a (a_i),
        .b (b_i),
        .y (lg_res)
    );

    assign res_o = is_log ? lg_res : ar_sum;

    alu_flag_reg #(.W(W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .we      (flag_we_i),
        .is_logic(is_log),
        .res     (res_o),
        .ar_cf   (ar_cf),
        .ar_af   (ar_af),
        .ar_of   (ar_of),
        .flags_q (flags_q)
    );

    assign flags_o = flags_q;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            op_i,
    input  logic                  flag_we_i,
    input  logic [W-1:0]          res_o,
    input  logic [FLAG_BITS-1:0]  flags_o
);
    localparam int MSB = W - 1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flags_o == '0)); // R10

    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !flag_we_i |=> $stable(flags_o)); // R9

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i[2]) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0 && flags_o[5] == 1'b0)); // R8

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        flag_we_i |=> (flags_o[3] == ($past(res_o) == '0))); // R4

    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
        flag_we_i |=> (flags_o[4] == $past(res_o[MSB]))); // R4

    AST_PARITY_TRACKS: assert property (@(posedge clk) disable iff (rst)
        flag_we_i |=> (flags_o[1] == ~(^$past(res_o[7:0])))); // R5
endmodule

bind alu_flags_unit alu_flags_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .flag_we_i(flag_we_i),
    .res_o    (res_o),
    .flags_o  (flags_o)
);

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op_i = 3'd0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cin_i = 1'b0;
    logic         flag_we_i = 1'b0;
    logic [W-1:0] res_o;
    logic [5:0]   flags_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [5:0] exp_reg = '0;

    always #10 clk = ~clk;

    alu_flags_unit #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .cin_i(cin_i), .flag_we_i(flag_we_i), .res_o(res_o), .flags_o(flags_o)
    );

    function automatic logic [W-1:0] ref_res(input logic [2:0] op, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic c);
        case (op)
            3'd0: return a + b;
            3'd1: return a + b + {{(W-1){1'b0}}, c};
            3'd2: return a - b;
            3'd3: return a - b - {{(W-1){1'b0}}, c};
            3'd4: return a & b;
            3'd5: return a | b;
            3'd6: return a ^ b;
            default: return ~a;
        endcase
    endfunction

    function automatic logic [5:0] ref_flags(input logic [2:0] op, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic c);
        logic [W-1:0] r;
        logic [W+1:0] wide;
        logic cy, af, ov, cc;
        r  = ref_res(op, a, b, c);
        cc = (op == 3'd1 || op == 3'd3) ? c : 1'b0;
        cy = 1'b0; af = 1'b0; ov = 1'b0;
        if (op <= 3'd1) begin
            wide = {2'b00, a} + {2'b00, b} + {{(W+1){1'b0}}, cc};
            cy = wide[W];
            af = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cc}) > 5'd15;
            ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
        end else if (op <= 3'd3) begin
            cy = ({1'b0, a} < ({1'b0, b} + {{W{1'b0}}, cc}));
            af = ({1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'b0, cc}));
            ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        end
        return {ov, r[W-1], (r == '0), af, ~(^r[7:0]), cy};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at falling edge, check result, then check register after next rising edge.
    task automatic apply(input string req, input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c, input logic we);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; cin_i = c; flag_we_i = we;
        #2;
        check({req, " result (R2)"}, res_o, ref_res(op, a, b, c));
        if (we) exp_reg = ref_flags(op, a, b, c);
        @(posedge clk);
        #1;
        check({req, " flags (R9)"}, {{(W-6){1'b0}}, flags_o}, {{(W-6){1'b0}}, exp_reg});
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (2) @(posedge clk);
        #1;
        check("R10 reset clear", {{(W-6){1'b0}}, flags_o}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R3 R4 R6 unsigned wrap: all ones + 1 -> zero, carry, aux carry, even parity
        apply("R3 R4 R6 wrap", 3'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
        // R7 signed overflow on add
        apply("R7 add ovf", 3'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
        // R7 signed overflow on subtract
        apply("R7 sub ovf", 3'd2, 32'h8000_0000, 32'h1, 1'b0, 1'b1);
        // R3 R6 borrow out of top and of nibble
        apply("R3 R6 borrow", 3'd2, 32'h0, 32'h1, 1'b0, 1'b1);
        // R6 nibble carry only
        apply("R6 nibble", 3'd0, 32'h0000_000F, 32'h1, 1'b0, 1'b1);
        // R2 chained carry-in opcodes
        apply("R2 adc", 3'd1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1);
        apply("R2 sbb", 3'd3, 32'h5, 32'h5, 1'b1, 1'b1);
        // R5 parity over low byte only
        apply("R5 parity", 3'd5, 32'h0100_0003, 32'h0, 1'b0, 1'b1);
        // R8 logic clears carry, overflow, aux after an arithmetic set them
        apply("R8 setup", 3'd2, 32'h8000_0000, 32'h1, 1'b0, 1'b1);
        apply("R8 logic clear", 3'd4, 32'hF0F0_F0F0, 32'hFFFF_0000, 1'b0, 1'b1);
        // R9 hold while write enable is low
        apply("R9 hold", 3'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
        // R11 carry-in ignored by plain add/sub and logic, b ignored by NOT
        apply("R11 add cin", 3'd0, 32'h0000_00FF, 32'h1, 1'b1, 1'b1);
        apply("R11 sub cin", 3'd2, 32'h10, 32'h10, 1'b1, 1'b1);
        apply("R11 not", 3'd7, 32'h1234_5678, 32'hDEAD_BEEF, 1'b1, 1'b1);
        apply("R11 xor cin", 3'd6, 32'hAAAA_5555, 32'h5555_AAAA, 1'b1, 1'b1);

        // R1 R2 random over all opcodes at full width
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [W-1:0] a, b;
            op = 3'($urandom_range(0, 7));
            a  = $urandom();
            b  = $urandom();
            if (i % 5 == 0) b = a;
            if (i % 7 == 0) a = {1'b0, {(W-1){1'b1}}};
            apply("R1 random", op, a, b, 1'($urandom()), 1'($urandom()));
        end

        // R10 reset wins over write enable
        apply("R10 setup", 3'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1; flag_we_i = 1'b1; op_i = 3'd2; a_i = '0; b_i = 32'h1;
        @(posedge clk);
        #1;
        check("R10 reset priority", {{(W-6){1'b0}}, flags_o}, '0);
        @(negedge clk);
        rst = 1'b0;
        exp_reg = '0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule